// File: doc/BRIEF.md
# Serial Configuration Word Port

This block is the host-facing configuration port of a stereo audio converter. A host drives three plain wires: a data line, a shift clock and a load strobe. On each rising edge of the shift clock one data bit is taken in, least significant bit first, so after sixteen edges the register holds a full 16-bit word. When the load strobe falls, the top two bits of that word choose which of two internal configuration registers receives it. One register holds the level-control fields and the other holds the audio-format fields.

All three host wires are asynchronous to the block clock. They pass through a synchronizer, and their edges are detected in the block clock domain. The data line goes through the same number of stages as the shift clock, so each bit is taken in step with its own shift edge. A word whose bit 15 is 1 is not a valid target and is thrown away. Reserved bits are stored as written but do not drive any output. The decoded fields are brought out as plain level outputs.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the level register holds 0400h and the format register holds 0000h. So the attenuation code reads 400h, and every other output reads 0.
- R2: Bits are taken on the rising edge of the shift clock, and the first bit shifted becomes bit 0 of the word.
- R3: Shifting alone changes no output. The shifted word takes effect only when the load strobe falls, and a rising load strobe commits nothing.
- R4: A committed word with bits 15:14 = 00 updates the level register and leaves the format outputs unchanged. In that word, bits 10:0 are the attenuation code, bit 12 is mute and bit 13 is the de-emphasis enable.
- R5: A committed word with bits 15:14 = 01 updates the format register and leaves the level outputs unchanged. In that word, bit 13 = 1 selects LSB-first audio, bit 12 = 1 selects 18-bit audio, bit 5 = 1 selects the long zero-detect period, bits 3:2 give the de-emphasis rate code (0 to 3), and bit 1 = 1 enables frame/PWM sync.
- R6: A committed word with bit 15 = 1 is discarded, and both registers stay unchanged.
- R7: When more than 16 bits are shifted before the load strobe falls, the last 16 bits shifted form the word.
- R8: Reserved bits of the format register (11:6, 4, 0) affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sdi | input | 1 | Serial data from the host, LSB first |
| host_sclk | input | 1 | Host shift clock; data is taken on its rising edge |
| host_load | input | 1 | Load strobe; the word commits on its falling edge |
| atten_code_o | output | 11 | Attenuation code |
| mute_o | output | 1 | Channel mute |
| deemph_en_o | output | 1 | De-emphasis enable |
| lsb_first_o | output | 1 | Audio data is LSB first |
| wide_sample_o | output | 1 | Audio samples are 18 bits |
| zdet_long_o | output | 1 | Long zero-detect period selected |
| deemph_rate_o | output | 2 | De-emphasis rate code |
| frame_sync_o | output | 1 | Frame clock and PWM synchronized |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 11-bit attenuation code and a two-stage synchronizer. Each host wire phase is held for four block clocks, which leaves the synchronizer room to settle. With these values every field position and all four rate codes can be reached, along with both select values and both rejected select patterns. The bench also covers an over-long shift of 20 bits and a reset in the middle of the run.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int CFG_W = 14;
  localparam logic [1:0] SEL_LEVEL  = 2'b00;
  localparam logic [1:0] SEL_FORMAT = 2'b01;
  localparam logic [CFG_W-1:0] LEVEL_RST  = 14'h0400;
  localparam logic [CFG_W-1:0] FORMAT_RST = 14'h0000;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
  parameter bit RISING = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else prev_q <= lvl_i;
  end

  if (RISING) begin : g_rise
    assign pulse_o = lvl_i & ~prev_q;
  end else begin : g_fall
    assign pulse_o = ~lvl_i & prev_q;
  end

  // a pulse is never followed by another pulse on the next cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (shift_i) sh_q <= {bit_i, sh_q[W-1:1]};
  end

  assign word_o = sh_q;

  // newest bit enters at the top, so the first bit ends at bit 0
  assert_lsb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> (sh_q[W-1] == $past(bit_i)) && (sh_q[W-2:0] == $past(sh_q[W-1:1])));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(sh_q));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_port_pkg::*;
#(
  parameter int W = 16,
  parameter int ATT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [W-1:0]     word_i,
  output logic [ATT_W-1:0] atten_code_o,
  output logic             mute_o,
  output logic             deemph_en_o,
  output logic             lsb_first_o,
  output logic             wide_sample_o,
  output logic             zdet_long_o,
  output logic [1:0]       deemph_rate_o,
  output logic             frame_sync_o
);
  logic [CFG_W-1:0] level_q, format_q;
  logic [1:0] sel;
  logic wr_level, wr_format;

  assign sel       = word_i[W-1:W-2];
  assign wr_level  = commit_i && (sel == SEL_LEVEL);
  assign wr_format = commit_i && (sel == SEL_FORMAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= LEVEL_RST;
      format_q <= FORMAT_RST;
    end else begin
      if (wr_level)  level_q  <= word_i[CFG_W-1:0];
      if (wr_format) format_q <= word_i[CFG_W-1:0];
    end
  end

  assign atten_code_o  = level_q[ATT_W-1:0];
  assign mute_o        = level_q[12];
  assign deemph_en_o   = level_q[13];
  assign lsb_first_o   = format_q[13];
  assign wide_sample_o = format_q[12];
  assign zdet_long_o   = format_q[5];
  assign deemph_rate_o = format_q[3:2];
  assign frame_sync_o  = format_q[1];

  assert_no_commit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(level_q) && $stable(format_q));
  assert_level_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && word_i[W-1:W-2] == 2'b00) |=> level_q == $past(word_i[CFG_W-1:0]) && $stable(format_q));
  assert_format_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && word_i[W-1:W-2] == 2'b01) |=> format_q == $past(word_i[CFG_W-1:0]) && $stable(level_q));
  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && word_i[W-1]) |=> $stable(level_q) && $stable(format_q));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int WORD_W = 16,
  parameter int ATT_W = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sdi,
  input  logic             host_sclk,
  input  logic             host_load,
  output logic [ATT_W-1:0] atten_code_o,
  output logic             mute_o,
  output logic             deemph_en_o,
  output logic             lsb_first_o,
  output logic             wide_sample_o,
  output logic             zdet_long_o,
  output logic [1:0]       deemph_rate_o,
  output logic             frame_sync_o
);
  localparam int NWIRE = 3;
  localparam logic [NWIRE-1:0] WIRE_RST = 3'b100;

  logic [NWIRE-1:0] sync_v;
  logic shift_p, load_p;
  logic [WORD_W-1:0] word;

  cfg_sync #(.W(NWIRE), .STAGES(SYNC_STAGES), .RST_VAL(WIRE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({host_load, host_sclk, host_sdi}), .sync_o(sync_v));

  cfg_edge #(.RISING(1'b1), .RST_VAL(WIRE_RST[1])) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sync_v[1]), .pulse_o(shift_p));

  cfg_edge #(.RISING(1'b0), .RST_VAL(WIRE_RST[2])) u_load_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sync_v[2]), .pulse_o(load_p));

  cfg_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_p), .bit_i(sync_v[0]), .word_o(word));

  cfg_regbank #(.W(WORD_W), .ATT_W(ATT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(load_p), .word_i(word),
    .atten_code_o(atten_code_o), .mute_o(mute_o), .deemph_en_o(deemph_en_o),
    .lsb_first_o(lsb_first_o), .wide_sample_o(wide_sample_o),
    .zdet_long_o(zdet_long_o), .deemph_rate_o(deemph_rate_o),
    .frame_sync_o(frame_sync_o));
endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int NVEC = 9;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h2155, 16'h602E, 16'h1001, 16'h5004, 16'h8FFF,
    16'hC123, 16'h4FD1, 16'h0400, 16'h4008};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sdi = 1'b0, host_sclk = 1'b0, host_load = 1'b1;
  logic [10:0] atten_code_o;
  logic mute_o, deemph_en_o, lsb_first_o, wide_sample_o, zdet_long_o, frame_sync_o;
  logic [1:0] deemph_rate_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_level, m_format;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_port dut (
    .clk(clk), .rst_n(rst_n), .host_sdi(host_sdi), .host_sclk(host_sclk),
    .host_load(host_load), .atten_code_o(atten_code_o), .mute_o(mute_o),
    .deemph_en_o(deemph_en_o), .lsb_first_o(lsb_first_o),
    .wide_sample_o(wide_sample_o), .zdet_long_o(zdet_long_o),
    .deemph_rate_o(deemph_rate_o), .frame_sync_o(frame_sync_o));

  function automatic logic [18:0] expect_of(logic [15:0] lv, logic [15:0] fm);
    return {lv[10:0], lv[12], lv[13], fm[13], fm[12], fm[5], fm[3:2], fm[1]};
  endfunction

  task automatic check(input string tag);
    logic [18:0] got, exp;
    got = {atten_code_o, mute_o, deemph_en_o, lsb_first_o, wide_sample_o,
           zdet_long_o, deemph_rate_o, frame_sync_o};
    exp = expect_of(m_level, m_format);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); host_sdi = v[i];
      repeat (HOLD) @(negedge clk); host_sclk = 1'b1;
      repeat (HOLD) @(negedge clk); host_sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk); host_load = 1'b0;
    repeat (HOLD) @(negedge clk); host_load = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic model(input logic [15:0] w);
    if (!w[15]) begin
      if (w[14]) m_format = w; else m_level = w;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_level = 16'h0400; m_format = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 reset defaults");

    for (int k = 0; k < NVEC; k++) begin
      shift_bits({16'h0, VEC[k]}, 16);
      pulse_load();
      model(VEC[k]);
      if (VEC[k][15]) check("R6 rejected word");
      else if (VEC[k][14]) check("R5 R2 R8 format word");
      else check("R4 R2 level word");
    end

    shift_bits({16'h0, 16'h1234}, 16);
    check("R3 shift without load");
    pulse_load();
    model(16'h1234);
    check("R3 load after shift");

    shift_bits({12'h0, 16'h4022, 4'hA}, 20);
    pulse_load();
    model(16'h4022);
    check("R7 last sixteen bits");

    @(negedge clk); host_load = 1'b0;
    repeat (HOLD) @(negedge clk);
    shift_bits({16'h0, 16'h0155}, 16);
    @(negedge clk); host_load = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 rising load commits nothing");

    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    m_level = 16'h0400; m_format = 16'h0000;
    repeat (6) @(negedge clk);
    check("R1 mid-run reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule